// File: doc/BRIEF.md
# Host Register Port with Command/Data Phases and Indexed Tables

This block is the host-facing front end of a display controller that sits on a 16-bit parallel bus with a command/data select line. A write in the command phase selects one of 256 byte-wide register addresses. Data-phase reads and writes then act on the selected register and step the address forward by two. The address holds still on the three streaming ports, so a host can push many words to one port without re-addressing it.

Two of those fixed ports front internal tables. Each table has its own index register. A data access to the table's data port touches the entry the index points at and then bumps that index. The small filter-coefficient table stops at its end: once the index reaches the entry count, further accesses have no effect. The 256-entry gamma table wraps around. The pixel stream port sends every written word out as a one-cycle output strobe. A programmable dummy-access count lets the host make the block skip a number of bus cycles, for example after a mode change.

Only a few control registers are modelled, and only as far as their write masks and read encodings go. The host bus is synchronous. Read data comes back one cycle after the read strobe, and an access to an address that is not implemented raises a one-cycle error pulse.

Top module: `disp_host_regif`

## Requirements
- R1: A write with `isCmd` high loads the register address from `wrData[7:0]`. Bits 15:8 are ignored.
- R2: After every data-phase read or write that is not swallowed, the register address advances by 2, modulo 256. The exceptions are addresses 0x90 (pixel stream), 0x5A (filter coefficient data) and 0xB8 (gamma data), where the address stays put. A read advances the address whatever the level of `isCmd`.
- R3: Writing value v to 0x04 stores the divider as (v & 0x3F) + 1. Reading 0x04 returns the stored divider minus one, with bit 7 set, which is (v & 0x3F) | 0x80.
- R4: Writes to the display mode register (0x68) are masked with 0xB7. Writes to the gamma enable register (0xB4) are masked with 0x87. The masked value is read back.
- R5: Writing 0x58 sets the filter index to `wrData[4:0]`, and reading 0x58 returns the index. A data access at 0x5A reads or writes coefficient[index] and then increments the index, but only while the index is below 32. When the index is 32, writes to 0x5A change nothing, reads return 0, and the index stays at 32.
- R6: Writing 0xB6 sets the 8-bit gamma index. A data access at 0xB8 reads or writes gamma[index] and then increments the index, with 255 wrapping to 0.
- R7: Writing 0xFC loads the dummy count from `wrData[3:0]`. While the count is non-zero, each access (command write, data write or read) is ignored, changes no state and decrements the count. A swallowed read still gives `rdValid` with data 0 and no error.
- R8: The interrupt status (0xF6) sets a bit in the cycle after `irqSet` carries a 1 in that bit. A write to 0xF6 ANDs the stored status with `wrData[7:0]`. A set in the same cycle as the write wins.
- R9: A data access to an address outside {0x04, 0x58, 0x5A, 0x68, 0x90, 0xB4, 0xB6, 0xB8, 0xF6, 0xFC} changes no register and raises `errPulse` for one cycle, aligned with the read data. A read of such an address returns 0. The address still advances as in R2.
- R10: `rdValid` is high exactly in the cycle after a cycle with `rdEn` high and `wrEn` low. When both strobes are high, only the write happens.
- R11: A data write to 0x90 gives `streamValid` high in the next cycle, with `streamData` equal to the full 16-bit word. A read of 0x90 returns 0 without an error.
- R12: After reset, the address is 0x00, the dummy count is 0, the divider reads 0x80, the other registers, indices and table entries are 0, and all output strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| isCmd | input | 1 | High marks a write as an address (command) write |
| wrData | input | 16 | Write data / address |
| irqSet | input | 8 | Interrupt status set bits |
| rdData | output | 16 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| errPulse | output | 1 | Access to an unimplemented address |
| streamValid | output | 1 | A pixel stream word was written |
| streamData | output | 16 | Last pixel stream word |

## Verification
The hardest state to reach is the filter table at its end bound: the index has to sit at exactly 32 while the address is parked on 0x5A, and an earlier dummy count must not hide the accesses that prove the bound holds. Directed sequences write the index to 30, step it past the end, and read the index back through the normal address walk. Gamma wrap and dummy-count skipping get the same directed treatment. A long random mix of address, read and write cycles, with random interrupt sets on top, is then compared read by read against a bench model of every register and table.

// File: rtl/disp_regif_pkg.sv
package disp_regif_pkg;

  localparam logic [7:0] ADDR_PLLDIV = 8'h04;
  localparam logic [7:0] ADDR_FIDX   = 8'h58;
  localparam logic [7:0] ADDR_FDATA  = 8'h5A;
  localparam logic [7:0] ADDR_MODE   = 8'h68;
  localparam logic [7:0] ADDR_STREAM = 8'h90;
  localparam logic [7:0] ADDR_GEN    = 8'hB4;
  localparam logic [7:0] ADDR_GIDX   = 8'hB6;
  localparam logic [7:0] ADDR_GDATA  = 8'hB8;
  localparam logic [7:0] ADDR_IRQ    = 8'hF6;
  localparam logic [7:0] ADDR_DUMMY  = 8'hFC;

  localparam logic [7:0] MASK_MODE   = 8'hB7;
  localparam logic [7:0] MASK_GEN    = 8'h87;
  localparam int unsigned ADDR_STEP  = 2;

  // strobes from control to datapath, one cycle of effect each
  typedef struct packed {
    logic        wr;      // data-phase write, not swallowed
    logic        rd;      // read, not swallowed
    logic        rdDrop;  // read swallowed by dummy count
    logic [7:0]  addr;
    logic [15:0] data;
  } ctlStrobe_t;

  function automatic logic holdsAddr(input logic [7:0] a);
    return (a == ADDR_STREAM) || (a == ADDR_FDATA) || (a == ADDR_GDATA);
  endfunction

endpackage

// File: rtl/disp_host_regif_ctrl.sv
module disp_host_regif_ctrl
  import disp_regif_pkg::*;
#(
  parameter int SWALLOW_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 isCmd,
  input  logic [15:0]          wrData,
  output ctlStrobe_t           strobe,
  output logic [7:0]           regAddr,
  output logic [SWALLOW_W-1:0] swallowCnt
);

  logic isWr, isRd, drop, anyAccess;

  always_comb begin
    isWr      = wrEn;
    isRd      = rdEn && !wrEn;
    anyAccess = isWr || isRd;
    drop      = (swallowCnt != '0);
    strobe.wr     = isWr && !isCmd && !drop;
    strobe.rd     = isRd && !drop;
    strobe.rdDrop = isRd && drop;
    strobe.addr   = regAddr;
    strobe.data   = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swallowCnt <= '0;
    end else if (drop && anyAccess) begin
      swallowCnt <= swallowCnt - 1'b1;
    end else if (strobe.wr && regAddr == ADDR_DUMMY) begin
      swallowCnt <= wrData[SWALLOW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddr <= 8'h00;
    end else if (isWr && isCmd && !drop) begin
      regAddr <= wrData[7:0];
    end else if ((strobe.wr || strobe.rd) && !holdsAddr(regAddr)) begin
      regAddr <= regAddr + 8'(ADDR_STEP);
    end
  end

endmodule

// File: rtl/disp_host_regif_dp.sv
module disp_host_regif_dp
  import disp_regif_pkg::*;
#(
  parameter int COEF_DEPTH  = 32,
  parameter int GAMMA_DEPTH = 256,
  parameter int SWALLOW_W   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  input  logic [SWALLOW_W-1:0] swallowCnt,
  input  logic [7:0]           irqSet,
  output logic [15:0]          rdData,
  output logic                 rdValid,
  output logic                 errPulse,
  output logic                 streamValid,
  output logic [15:0]          streamData
);

  localparam int CIDX_W = $clog2(COEF_DEPTH) + 1;
  localparam int GIDX_W = $clog2(GAMMA_DEPTH);

  logic [6:0]        pllDiv;
  logic [7:0]        dispMode;
  logic [7:0]        gammaEn;
  logic [7:0]        irqStatus;
  logic [CIDX_W-1:0] coefIdx;
  logic [GIDX_W-1:0] gammaIdx;
  logic [7:0]        coefTab  [COEF_DEPTH];
  logic [7:0]        gammaTab [GAMMA_DEPTH];

  logic        coefLive, hit;
  logic [15:0] rdMux;
  logic [5:0]  pllRead;

  always_comb begin
    coefLive = (coefIdx < CIDX_W'(COEF_DEPTH));
    pllRead  = 6'(pllDiv - 7'd1);
    hit      = 1'b1;
    rdMux    = 16'h0000;
    case (ctl.addr)
      ADDR_PLLDIV: rdMux = {8'h00, 2'b10, pllRead};
      ADDR_FIDX:   rdMux = 16'(coefIdx);
      ADDR_FDATA:  rdMux = coefLive ? {8'h00, coefTab[coefIdx[CIDX_W-2:0]]} : 16'h0000;
      ADDR_MODE:   rdMux = {8'h00, dispMode};
      ADDR_STREAM: rdMux = 16'h0000;
      ADDR_GEN:    rdMux = {8'h00, gammaEn};
      ADDR_GIDX:   rdMux = 16'(gammaIdx);
      ADDR_GDATA:  rdMux = {8'h00, gammaTab[gammaIdx]};
      ADDR_IRQ:    rdMux = {8'h00, irqStatus};
      ADDR_DUMMY:  rdMux = 16'(swallowCnt);
      default:     hit   = 1'b0;
    endcase
  end

  // control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pllDiv    <= 7'd1;
      dispMode  <= '0;
      gammaEn   <= '0;
      irqStatus <= '0;
    end else begin
      if (ctl.wr) begin
        case (ctl.addr)
          ADDR_PLLDIV: pllDiv   <= 7'(ctl.data[5:0]) + 7'd1;
          ADDR_MODE:   dispMode <= ctl.data[7:0] & MASK_MODE;
          ADDR_GEN:    gammaEn  <= ctl.data[7:0] & MASK_GEN;
          default: ;
        endcase
      end
      irqStatus <= ((ctl.wr && ctl.addr == ADDR_IRQ) ? (irqStatus & ctl.data[7:0])
                                                     : irqStatus) | irqSet;
    end
  end

  // filter coefficient table: saturating index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefIdx <= '0;
      for (int i = 0; i < COEF_DEPTH; i++) coefTab[i] <= '0;
    end else if (ctl.wr && ctl.addr == ADDR_FIDX) begin
      coefIdx <= {1'b0, ctl.data[CIDX_W-2:0]};
    end else if ((ctl.wr || ctl.rd) && ctl.addr == ADDR_FDATA && coefLive) begin
      if (ctl.wr) coefTab[coefIdx[CIDX_W-2:0]] <= ctl.data[7:0];
      coefIdx <= coefIdx + 1'b1;
    end
  end

  // gamma table: wrapping index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gammaIdx <= '0;
      for (int i = 0; i < GAMMA_DEPTH; i++) gammaTab[i] <= '0;
    end else if (ctl.wr && ctl.addr == ADDR_GIDX) begin
      gammaIdx <= ctl.data[GIDX_W-1:0];
    end else if ((ctl.wr || ctl.rd) && ctl.addr == ADDR_GDATA) begin
      if (ctl.wr) gammaTab[gammaIdx] <= ctl.data[7:0];
      gammaIdx <= gammaIdx + 1'b1;
    end
  end

  // registered bus-side outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData      <= '0;
      rdValid     <= 1'b0;
      errPulse    <= 1'b0;
      streamValid <= 1'b0;
      streamData  <= '0;
    end else begin
      rdValid     <= ctl.rd || ctl.rdDrop;
      rdData      <= ctl.rd ? rdMux : 16'h0000;
      errPulse    <= (ctl.wr || ctl.rd) && !hit;
      streamValid <= ctl.wr && ctl.addr == ADDR_STREAM;
      if (ctl.wr && ctl.addr == ADDR_STREAM) streamData <= ctl.data;
    end
  end

endmodule

// File: rtl/disp_host_regif.sv
module disp_host_regif
  import disp_regif_pkg::*;
#(
  parameter int COEF_DEPTH  = 32,
  parameter int GAMMA_DEPTH = 256,
  parameter int SWALLOW_W   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        isCmd,
  input  logic [15:0] wrData,
  input  logic [7:0]  irqSet,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        errPulse,
  output logic        streamValid,
  output logic [15:0] streamData
);

  ctlStrobe_t           ctlStrobe;
  logic [7:0]           regAddr;
  logic [SWALLOW_W-1:0] swallowCnt;

  disp_host_regif_ctrl #(.SWALLOW_W(SWALLOW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .isCmd(isCmd),
    .wrData(wrData), .strobe(ctlStrobe), .regAddr(regAddr),
    .swallowCnt(swallowCnt)
  );

  disp_host_regif_dp #(
    .COEF_DEPTH(COEF_DEPTH), .GAMMA_DEPTH(GAMMA_DEPTH), .SWALLOW_W(SWALLOW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlStrobe), .swallowCnt(swallowCnt),
    .irqSet(irqSet), .rdData(rdData), .rdValid(rdValid),
    .errPulse(errPulse), .streamValid(streamValid), .streamData(streamData)
  );

endmodule

// File: rtl/disp_host_regif_chk.sv
module disp_host_regif_chk #(
  parameter int SWALLOW_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic                 isCmd,
  input logic [15:0]          rdData,
  input logic                 rdValid,
  input logic                 errPulse,
  input logic                 streamValid,
  input logic [7:0]           regAddr,
  input logic [SWALLOW_W-1:0] swallowCnt
);

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> rdValid); // R10

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && !wrEn) |=> !rdValid); // R10

  AST_ERR_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(wrEn || rdEn)); // R9

  AST_STREAM_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    streamValid |-> $past(wrEn && !isCmd)); // R11

  AST_STREAM_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !isCmd && regAddr == 8'h90 && swallowCnt == '0) |=> (regAddr == 8'h90)); // R2

  AST_DUMMY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (swallowCnt != '0 && (wrEn || rdEn)) |=> (swallowCnt == $past(swallowCnt) - 1'b1)); // R7

  AST_DUMMY_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (swallowCnt != '0) |=> $stable(regAddr)); // R7

  AST_DUMMY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (swallowCnt != '0 && rdEn && !wrEn) |=> (rdData == 16'h0000 && !errPulse)); // R7

endmodule

bind disp_host_regif disp_host_regif_chk #(.SWALLOW_W(SWALLOW_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .isCmd(isCmd),
  .rdData(rdData), .rdValid(rdValid), .errPulse(errPulse),
  .streamValid(streamValid), .regAddr(regAddr), .swallowCnt(swallowCnt)
);

// File: tb/tb_disp_host_regif.sv
module tb_disp_host_regif;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, isCmd = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  irqSet = '0;
  logic [15:0] rdData, streamData;
  logic        rdValid, errPulse, streamValid;

  always #2.5 clk = ~clk;

  disp_host_regif dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .isCmd(isCmd),
    .wrData(wrData), .irqSet(irqSet), .rdData(rdData), .rdValid(rdValid),
    .errPulse(errPulse), .streamValid(streamValid), .streamData(streamData)
  );

  int nChk = 0, nBad = 0;
  bit finished = 0;

  // bench model, built from the requirements
  logic [7:0] mAddr, mPll, mMode, mGen, mStat, mGi;
  logic [5:0] mFi;
  logic [3:0] mSw;
  logic [7:0] mCoef [32];
  logic [7:0] mGam  [256];

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  function automatic logic known(input logic [7:0] a);
    return a == 8'h04 || a == 8'h58 || a == 8'h5A || a == 8'h68 || a == 8'h90 ||
           a == 8'hB4 || a == 8'hB6 || a == 8'hB8 || a == 8'hF6 || a == 8'hFC;
  endfunction

  function automatic logic [7:0] nextAddr(input logic [7:0] a);
    return (a == 8'h90 || a == 8'h5A || a == 8'hB8) ? a : a + 8'd2;
  endfunction

  // one bus cycle, modelled then compared
  task automatic doOp(input logic w, input logic r, input logic c,
                      input logic [15:0] d, input logic [7:0] irq, input string tag);
    logic expV = 0, expE = 0, expS = 0;
    logic [15:0] expD = 0;
    logic isR = r && !w;
    logic [7:0] a = mAddr;
    if ((w || isR) && mSw != 0) begin
      mSw--;
      expV = isR;
    end else if (w && c) begin
      mAddr = d[7:0];
    end else if (w) begin
      case (a)
        8'h04: mPll = {2'b0, d[5:0]};
        8'h58: mFi = {1'b0, d[4:0]};
        8'h5A: if (mFi < 32) begin mCoef[mFi[4:0]] = d[7:0]; mFi++; end
        8'h68: mMode = d[7:0] & 8'hB7;
        8'h90: expS = 1;
        8'hB4: mGen = d[7:0] & 8'h87;
        8'hB6: mGi = d[7:0];
        8'hB8: begin mGam[mGi] = d[7:0]; mGi++; end
        8'hF6: mStat = mStat & d[7:0];
        8'hFC: mSw = d[3:0];
        default: expE = 1;
      endcase
      mAddr = nextAddr(a);
    end else if (isR) begin
      expV = 1;
      case (a)
        8'h04: expD = {8'h0, 8'h80 | mPll};
        8'h58: expD = 16'(mFi);
        8'h5A: if (mFi < 32) begin expD = 16'(mCoef[mFi[4:0]]); mFi++; end
        8'h68: expD = 16'(mMode);
        8'hB4: expD = 16'(mGen);
        8'hB6: expD = 16'(mGi);
        8'hB8: begin expD = 16'(mGam[mGi]); mGi++; end
        8'hF6: expD = 16'(mStat);
        8'hFC: expD = 16'(mSw);
        default: expE = !known(a);
      endcase
      mAddr = nextAddr(a);
    end
    mStat = mStat | irq;
    // drive
    wrEn = w; rdEn = r; isCmd = c; wrData = d; irqSet = irq;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; rdEn = 0; isCmd = 0; irqSet = 0;
    check(rdValid == expV, {tag, " valid"}, 16'(rdValid), 16'(expV));
    if (expV) check(rdData == expD, {tag, " data"}, rdData, expD);
    check(errPulse == expE, {tag, " err"}, 16'(errPulse), 16'(expE));
    check(streamValid == expS, {tag, " stream"}, 16'(streamValid), 16'(expS));
    if (expS) check(streamData == d, {tag, " streamData"}, streamData, d);
  endtask

  task automatic cmd(input logic [7:0] a, input string tag);
    doOp(1, 0, 1, {8'hA5, a}, 0, tag);
  endtask
  task automatic wr(input logic [15:0] d, input string tag);
    doOp(1, 0, 0, d, 0, tag);
  endtask
  task automatic rd(input string tag);
    doOp(0, 1, 0, 16'h0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    finish();
  end

  initial begin
    mAddr = 0; mPll = 0; mMode = 0; mGen = 0; mStat = 0; mGi = 0; mFi = 0; mSw = 0;
    for (int i = 0; i < 32; i++) mCoef[i] = 0;
    for (int i = 0; i < 256; i++) mGam[i] = 0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R12: reset state
    check(!rdValid && !errPulse && !streamValid, "R12 idle outputs", 16'({rdValid, errPulse, streamValid}), 16'h0);
    rd("R12 read at address 0 (unimplemented, R9)");
    cmd(8'h04, "R1 select divider");
    rd("R12 divider reset value");
    // R1 with high byte, R3 divider encoding
    cmd(8'h04, "R1 addr");
    wr(16'hFF3F, "R3 divider max");
    cmd(8'h04, "R1"); rd("R3 divider readback");
    cmd(8'h04, "R1"); wr(16'h0005, "R3"); cmd(8'h04, "R1"); rd("R3 divider small");
    // R4 masks
    cmd(8'h68, "R1"); wr(16'h00FF, "R4 mode write"); cmd(8'h68, "R1"); rd("R4 mode mask");
    cmd(8'hB4, "R1"); wr(16'h00FF, "R4 gamma enable write"); cmd(8'hB4, "R1"); rd("R4 gamma enable mask");
    // R2 advance and wrap
    cmd(8'hFE, "R2 top"); rd("R2 read 0xFE"); rd("R2 wrapped to 0x00");
    // R5 filter bound
    cmd(8'h58, "R5"); wr(16'h00FE, "R5 index 30 from masked 0xFE");
    wr(16'h0011, "R5 coef 30"); wr(16'h0022, "R5 coef 31"); wr(16'h0033, "R5 write at 32 ignored");
    rd("R5 read at 32 returns zero");
    cmd(8'h58, "R1"); rd("R5 index stuck at 32");
    rd("R2 address reached 0x5A after index read, R5 still zero");
    cmd(8'h58, "R1"); wr(16'h001E, "R5 index 30");
    rd("R5 coef 30 readback"); rd("R5 coef 31 readback");
    // R6 gamma wrap
    cmd(8'hB6, "R6"); wr(16'h00FE, "R6 index 254");
    wr(16'h0001, "R6 g254"); wr(16'h0002, "R6 g255"); wr(16'h0003, "R6 g0 after wrap");
    cmd(8'hB6, "R6"); rd("R6 index wrapped to 1");
    cmd(8'hB6, "R6"); wr(16'h00FF, "R6"); rd("R6 g255"); rd("R6 g0"); rd("R6 g1");
    // R11 stream
    cmd(8'h90, "R11"); wr(16'hBEEF, "R11 stream word"); wr(16'h1234, "R11 stream word 2"); rd("R11 stream read zero");
    // R7 dummy count
    cmd(8'hFC, "R7"); wr(16'h0003, "R7 load 3");
    rd("R7 swallowed read"); cmd(8'h68, "R7 swallowed cmd"); wr(16'h0000, "R7 swallowed write");
    rd("R7 read after swallow at 0xFE (R9)");
    cmd(8'h68, "R7"); rd("R7 mode untouched by swallowed write");
    // R8 interrupt status
    doOp(0, 0, 0, 0, 8'hF0, "R8 set");
    cmd(8'hF6, "R8"); wr(16'h003F, "R8 clear by AND");
    cmd(8'hF6, "R8"); rd("R8 status after AND");
    cmd(8'hF6, "R8"); doOp(1, 0, 0, 16'h0000, 8'h01, "R8 set beats clear");
    cmd(8'hF6, "R8"); rd("R8 set won");
    // R10 both strobes
    cmd(8'h68, "R10"); doOp(1, 1, 0, 16'h0004, 0, "R10 write wins, no rdValid");
    cmd(8'h68, "R10"); rd("R10 write landed");
    // R9 write to unimplemented
    cmd(8'h10, "R9"); wr(16'h00AA, "R9 write error pulse");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 99);
      logic [7:0] irq = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00;
      if (k < 30) begin
        logic [7:0] pick [11] = '{8'h04, 8'h58, 8'h5A, 8'h68, 8'h90, 8'hB4, 8'hB6, 8'hB8, 8'hF6, 8'hFC, 8'h00};
        logic [7:0] a = pick[$urandom_range(0, 10)];
        if (a == 8'h00) a = 8'($urandom);
        doOp(1, 0, 1, 16'($urandom), irq, "R2 random cmd");
        doOp(1, 0, 1, {8'h00, a}, 0, "R1 random cmd");
      end else if (k < 62) begin
        logic [15:0] d = 16'($urandom);
        if (mAddr == 8'hFC) d[3:2] = 2'b00;
        doOp(1, 0, 0, d, irq, "R2 random write");
      end else if (k < 97) begin
        doOp(0, 1, 0, 16'h0, irq, "R2 random read");
      end else begin
        doOp(1, 1, 0, 16'($urandom), irq, "R10 random both");
      end
    end
    finish();
  end

endmodule